// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers reset requests from seven places and turns them into six reset lines. The sources are an external hard-reset pin, an external soft-reset pin, power-up, a software watchdog, a double bus fault, a loss of clock, and the CPU's own reset instruction. Each source asserts its own subset of the lines. These are: the CPU core reset, the internal reset for on-chip logic, the internal system reset, the clock-generator reset, and open-drain drive enables for the hard and soft reset pins.

Each reset episode is stretched to at least 512 clock cycles. It is held for longer while any source that took part in it is still active. A new request arriving during an episode adds its lines and restarts the count. Once the lines drop, the block waits a 14-cycle rise window for the pins to float high. At the end of that window it looks at both pins once more. Only if neither pin is active does it raise the CPU-start indication.

Request inputs are asynchronous and pass through a two-flop synchroniser. Each pin is modelled by two signals: a sense input that carries only what external devices drive, and a drive-enable output. Power-up reset comes from the asynchronous `rst_ni`.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, all six lines are high and `cpu_start_o` is low. After `rst_ni` rises, the lines stay high through the 512th rising clock edge.
- R2: An external soft-reset request (`soft_pin_ni` low) asserts `cpu_rst_o`, `int_rst_o` and `soft_pin_drv_o` only. In the bench's vector {cpu, int, int_sys, clk, hard_drv, soft_drv} this is 110001.
- R3: An external hard-reset request (`hard_pin_ni` low) asserts all six lines (vector 111111).
- R4: A watchdog request asserts every line except `clk_rst_o` (vector 111011).
- R5: A double bus fault request or a loss-of-clock request each asserts all six lines (vector 111111).
- R6: A reset-instruction request asserts only `int_rst_o` and `soft_pin_drv_o` (vector 010001). It never asserts `cpu_rst_o`.
- R7: A request that is active for at least two clocks, including one shorter than 32 clocks, keeps the lines asserted for exactly 512 cycles. Lines rise on the third rising edge after the input changes.
- R8: When a source is held active for N cycles with N > 512, the lines stay asserted for N cycles. Release follows source negation with the same 2-cycle latency as assertion.
- R9: Requests that overlap produce the union of their line sets. A request detected during an episode restarts the 512-cycle count, even when it lands in the very cycle the count would have released the lines.
- R10: `cpu_start_o` rises 14 cycles after the lines drop. A request seen during the rise window, or a pin active at its end, starts a new episode instead, and `cpu_start_o` stays low.
- R11: `cpu_start_o` is never high while any line is asserted. It stays high until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| hard_pin_ni | input | 1 | Hard-reset pin level as driven by external devices (low = request) |
| soft_pin_ni | input | 1 | Soft-reset pin level as driven by external devices (low = request) |
| wdog_req_i | input | 1 | Software watchdog reset request |
| dbl_fault_req_i | input | 1 | Double bus fault reset request |
| clk_loss_req_i | input | 1 | Loss-of-clock reset request |
| rst_instr_req_i | input | 1 | CPU reset-instruction request |
| cpu_rst_o | output | 1 | CPU core reset |
| int_rst_o | output | 1 | Internal reset for on-chip logic |
| int_sys_rst_o | output | 1 | Internal system reset |
| clk_rst_o | output | 1 | Clock-generator reset |
| hard_pin_drv_o | output | 1 | Drive hard-reset pin low |
| soft_pin_drv_o | output | 1 | Drive soft-reset pin low |
| cpu_start_o | output | 1 | CPU may begin its vector fetch |

## Verification
Two things can land on the same edge: detection of a new request, and expiry of the stretch counter that would otherwise release the lines. The bench provokes this by starting a double bus fault exactly 512 cycles after a watchdog request. The restart must win, and the bench judges this by an episode width of 1024 cycles and the merged vector 111111. A second case starts a soft request five cycles into the rise window. That must cancel the start, which the scoreboard sees as an episode that ends without any `cpu_start_o`.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_SRC  = 7;
  localparam int NUM_LINE = 6;

  // source indices
  localparam int SRC_HARD_PIN  = 0;
  localparam int SRC_SOFT_PIN  = 1;
  localparam int SRC_POWER     = 2;
  localparam int SRC_WDOG      = 3;
  localparam int SRC_DBL_FAULT = 4;
  localparam int SRC_CLK_LOSS  = 5;
  localparam int SRC_RST_INSTR = 6;

  // line bit positions
  localparam int LN_SOFT_DRV = 0;
  localparam int LN_HARD_DRV = 1;
  localparam int LN_CLK      = 2;
  localparam int LN_INT_SYS  = 3;
  localparam int LN_INT      = 4;
  localparam int LN_CPU      = 5;

  typedef logic [NUM_LINE-1:0] line_vec_t;
  typedef logic [NUM_SRC-1:0]  src_vec_t;

  function automatic line_vec_t src_lines(int s);
    line_vec_t m;
    m = '0;
    case (s)
      SRC_HARD_PIN, SRC_POWER, SRC_DBL_FAULT, SRC_CLK_LOSS: m = '1;
      SRC_WDOG: begin
        m = '1;
        m[LN_CLK] = 1'b0;
      end
      SRC_SOFT_PIN: begin
        m[LN_CPU]      = 1'b1;
        m[LN_INT]      = 1'b1;
        m[LN_SOFT_DRV] = 1'b1;
      end
      SRC_RST_INSTR: begin
        m[LN_INT]      = 1'b1;
        m[LN_SOFT_DRV] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int STRETCH_CYCLES = 512,
  parameter int RISE_CYCLES    = 14
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_lvl_i,
  output logic     active_o,
  output src_vec_t src_o,
  output logic     start_o
);
  localparam int CNT_W  = $clog2(STRETCH_CYCLES);
  localparam int RISE_W = $clog2(RISE_CYCLES);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STRETCH_CYCLES - 1);
  localparam logic [RISE_W-1:0] RISE_LAST = RISE_W'(RISE_CYCLES - 1);
  localparam src_vec_t PIN_MASK = src_vec_t'((1 << SRC_HARD_PIN) | (1 << SRC_SOFT_PIN));

  typedef enum logic [1:0] {ST_ACT, ST_RISE, ST_RUN} st_e;

  st_e               state;
  logic [CNT_W-1:0]  cnt;
  logic [RISE_W-1:0] rcnt;
  src_vec_t          src_q, req_prv;
  src_vec_t          new_req;
  logic              held, cnt_done;

  assign new_req  = req_lvl_i & ~req_prv;
  assign held     = |(req_lvl_i & src_q);
  assign cnt_done = (cnt == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_ACT;
      cnt     <= '0;
      rcnt    <= '0;
      src_q   <= src_vec_t'(1 << SRC_POWER);
      req_prv <= '0;
    end else begin
      req_prv <= req_lvl_i;
      if (|new_req) begin
        // new request wins over release and restarts the stretch
        state <= ST_ACT;
        cnt   <= '0;
        src_q <= ((state == ST_ACT) ? src_q : '0) | new_req;
      end else begin
        case (state)
          ST_ACT: begin
            if (!cnt_done) cnt <= cnt + 1'b1;
            else if (!held) begin
              state <= ST_RISE;
              rcnt  <= '0;
              src_q <= '0;
            end
          end
          ST_RISE: begin
            if (rcnt == RISE_LAST) begin
              if (|(req_lvl_i & PIN_MASK)) begin
                state <= ST_ACT;
                cnt   <= '0;
                src_q <= req_lvl_i & PIN_MASK;
              end else begin
                state <= ST_RUN;
              end
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign active_o = (state == ST_ACT);
  assign src_o    = src_q;
  assign start_o  = (state == ST_RUN);

  AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(cnt_done)); // R7
  AST_HOLD_WHILE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && held) |=> active_o); // R8
  AST_RISE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> ($past(rcnt) == RISE_LAST)); // R10
endmodule

// File: rtl/rstc_map.sv
module rstc_map
  import rstc_pkg::*;
(
  input  logic      active_i,
  input  src_vec_t  src_i,
  output line_vec_t lines_o
);
  line_vec_t acc [NUM_SRC+1];

  assign acc[0] = '0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign acc[i+1] = acc[i] | (src_i[i] ? src_lines(i) : line_vec_t'(0));
  end

  assign lines_o = active_i ? acc[NUM_SRC] : '0;
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int STRETCH_CYCLES = 512,
  parameter int RISE_CYCLES    = 14,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_pin_ni,
  input  logic soft_pin_ni,
  input  logic wdog_req_i,
  input  logic dbl_fault_req_i,
  input  logic clk_loss_req_i,
  input  logic rst_instr_req_i,
  output logic cpu_rst_o,
  output logic int_rst_o,
  output logic int_sys_rst_o,
  output logic clk_rst_o,
  output logic hard_pin_drv_o,
  output logic soft_pin_drv_o,
  output logic cpu_start_o
);
  src_vec_t  req_raw, req_lvl, src;
  line_vec_t lines;
  logic      active, start;

  always_comb begin
    req_raw                = '0;
    req_raw[SRC_HARD_PIN]  = ~hard_pin_ni;
    req_raw[SRC_SOFT_PIN]  = ~soft_pin_ni;
    req_raw[SRC_WDOG]      = wdog_req_i;
    req_raw[SRC_DBL_FAULT] = dbl_fault_req_i;
    req_raw[SRC_CLK_LOSS]  = clk_loss_req_i;
    req_raw[SRC_RST_INSTR] = rst_instr_req_i;
  end

  rstc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (req_lvl)
  );

  rstc_seq #(.STRETCH_CYCLES(STRETCH_CYCLES), .RISE_CYCLES(RISE_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_lvl_i(req_lvl),
    .active_o (active),
    .src_o    (src),
    .start_o  (start)
  );

  rstc_map u_map (
    .active_i(active),
    .src_i   (src),
    .lines_o (lines)
  );

  assign cpu_rst_o      = lines[LN_CPU];
  assign int_rst_o      = lines[LN_INT];
  assign int_sys_rst_o  = lines[LN_INT_SYS];
  assign clk_rst_o      = lines[LN_CLK];
  assign hard_pin_drv_o = lines[LN_HARD_DRV];
  assign soft_pin_drv_o = lines[LN_SOFT_DRV];
  assign cpu_start_o    = start;

  AST_CPU_WITHIN_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> int_rst_o); // R6
  AST_CLK_WITHIN_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rst_o |-> int_sys_rst_o); // R4
  AST_HARD_WITHIN_SOFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_pin_drv_o |-> soft_pin_drv_o); // R3
  AST_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_start_o |-> !(int_rst_o || soft_pin_drv_o)); // R11
endmodule

// File: tb/sys_reset_ctrl_tb.sv
`timescale 1ns/100ps
module sys_reset_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hard_pin_ni = 1'b1, soft_pin_ni = 1'b1;
  logic wdog = 1'b0, dbf = 1'b0, clk_loss = 1'b0, instr = 1'b0;
  logic cpu_rst, int_rst, int_sys_rst, clk_rst, hard_drv, soft_drv, cpu_start;
  logic [5:0] vec;

  always #2.5 clk = ~clk;

  sys_reset_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .hard_pin_ni(hard_pin_ni), .soft_pin_ni(soft_pin_ni),
    .wdog_req_i(wdog), .dbl_fault_req_i(dbf),
    .clk_loss_req_i(clk_loss), .rst_instr_req_i(instr),
    .cpu_rst_o(cpu_rst), .int_rst_o(int_rst), .int_sys_rst_o(int_sys_rst),
    .clk_rst_o(clk_rst), .hard_pin_drv_o(hard_drv), .soft_pin_drv_o(soft_drv),
    .cpu_start_o(cpu_start)
  );

  assign vec = {cpu_rst, int_rst, int_sys_rst, clk_rst, hard_drv, soft_drv};

  typedef struct {
    logic [5:0] lines;
    int         width;
    int         gap;   // -1: start must not follow
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [5:0] l, int w, int g, string tag);
    exp_t e;
    e.lines = l; e.width = w; e.gap = g; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_src(int idx, logic on);
    case (idx)
      0: hard_pin_ni = ~on;
      1: soft_pin_ni = ~on;
      3: wdog        = on;
      4: dbf         = on;
      5: clk_loss    = on;
      default: instr = on;
    endcase
  endtask

  task automatic pulse(int idx, int len);
    @(negedge clk);
    set_src(idx, 1'b1);
    repeat (len) @(negedge clk);
    set_src(idx, 1'b0);
  endtask

  task automatic wait_start(string tag);
    while (!cpu_start) @(negedge clk);
    chk(vec == 6'b0, tag, "lines while start high", int'(vec), 0);
    repeat (4) @(negedge clk);
  endtask

  // monitor: measure each episode and the gap to start, compare with queue
  initial begin
    bit in_ep = 0, pend = 0;
    int w = 0, g = 0;
    logic [5:0] acc = '0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (int_rst && !in_ep) begin
          if (pend) begin
            chk(cur.gap == -1, "R10", "start gap (restart)", g, cur.gap);
            pend = 0;
          end
          in_ep = 1; w = 0; acc = '0;
        end
        if (in_ep) begin
          if (int_rst) begin
            w++;
            acc |= vec;
          end else begin
            in_ep = 0;
            if (q.size() == 0) begin
              chk(1'b0, "R11", "unexpected episode", w, 0);
            end else begin
              cur = q.pop_front();
              chk(acc == cur.lines, cur.tag, "line set", int'(acc), int'(cur.lines));
              chk(w == cur.width, cur.tag, "width", w, cur.width);
              pend = 1; g = 1;
            end
          end
        end else if (pend) begin
          if (cpu_start) begin
            chk(g == cur.gap, "R10", "start gap", g, cur.gap);
            pend = 0;
          end else begin
            g++;
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state and power-up stretch
    repeat (4) @(negedge clk);
    chk(vec == 6'b111111 && !cpu_start, "R1", "reset state", int'({vec, cpu_start}), 126);
    push(6'b111111, 511, 14, "R1");
    #1 rst_ni = 1'b1;
    wait_start("R1");

    push(6'b110001, 512, 14, "R2");  pulse(1, 40); wait_start("R2");
    push(6'b111111, 512, 14, "R3");  pulse(0, 40); wait_start("R3");
    push(6'b111011, 512, 14, "R4");  pulse(3, 40); wait_start("R4");
    push(6'b111111, 512, 14, "R5");  pulse(4, 40); wait_start("R5");
    push(6'b111111, 512, 14, "R5");  pulse(5, 40); wait_start("R5");
    push(6'b010001, 512, 14, "R6");  pulse(6, 40); wait_start("R6");
    // R7 short pulse below 32 cycles
    push(6'b110001, 512, 14, "R7");  pulse(1, 3);  wait_start("R7");
    // R8 held sources
    push(6'b110001, 700, 14, "R8");  pulse(1, 700); wait_start("R8");
    push(6'b111011, 600, 14, "R8");  pulse(3, 600); wait_start("R8");

    // R9 overlap: watchdog 100 cycles after soft request
    push(6'b111011, 612, 14, "R9");
    @(negedge clk); soft_pin_ni = 1'b0;
    repeat (40) @(negedge clk); soft_pin_ni = 1'b1;
    repeat (60) @(negedge clk); wdog = 1'b1;
    repeat (40) @(negedge clk); wdog = 1'b0;
    wait_start("R9");

    // R9 new request detected on the terminal-count edge
    push(6'b111111, 1024, 14, "R9");
    @(negedge clk); wdog = 1'b1;
    repeat (40) @(negedge clk); wdog = 1'b0;
    repeat (472) @(negedge clk); dbf = 1'b1;
    repeat (40) @(negedge clk); dbf = 1'b0;
    wait_start("R9");

    // R10 request inside rise window cancels start
    push(6'b010001, 512, -1, "R6");
    push(6'b110001, 512, 14, "R10");
    pulse(6, 40);
    while (!int_rst) @(negedge clk);
    while (int_rst) @(negedge clk);
    repeat (4) @(negedge clk);
    pulse(1, 40);
    wait_start("R10");

    repeat (20) @(negedge clk);
    chk(cpu_start == 1'b1, "R11", "start held", int'(cpu_start), 1);
    chk(q.size() == 0, "R11", "pending items", q.size(), 0);
    finish_run();
  end
endmodule